// File: doc/BRIEF.md
# Two-Tap Fractional Clock Modulator

This block sits beside a tapped oscillator and decides, one oscillator cycle at a time, which of two neighbouring taps should drive the clock. The two candidates are the base tap and the tap one step above it. A 5-bit mix code sets how many cycles of each fixed 32-cycle frame use the upper tap. Adjacent taps are roughly 8% apart in frequency, so the long-run average frequency can be set in 1/32 steps inside that span. Switching taps during the frame also spreads the clock energy over a band instead of one line.

The upper-tap cycles are placed by comparing the bit-reversed frame position against the code. This scatters them evenly across the frame instead of grouping them. The tap index and code are captured only at a frame boundary, so each frame is built from a single setting. A separate disable input forces the base tap on the next cycle, wherever the frame happens to be. The top tap is never stepped past. The oscillator itself is outside this block.

Top module: `frac_tap_mod`

## Requirements
- R1: A frame is 32 clock cycles long. `frame_start` is high for the first cycle of each frame only. The first frame begins in the first cycle after reset is released.
- R2: With `mod_off` low for the whole frame and a base tap below 31, the number of cycles in the frame with `use_hi` = 1 equals the captured code (0 to 31). In every cycle, `tap_sel` equals the base tap plus `use_hi`.
- R3: Number frame positions p = 0..31, with p = 0 being the cycle in which `frame_start` is high. Position p uses the upper tap if and only if the 5-bit bit-reversal of p is less than the code. As a result, a code of 16 or less never produces two consecutive upper-tap cycles.
- R4: A captured code of 0 gives the base tap on every cycle of the frame.
- R5: `tap_idx` and `mix_code` are sampled only at the clock edge that begins a frame. A change at any other time has no effect on `tap_sel` or `use_hi` until the next frame.
- R6: If `mod_off` is high at a clock edge, the cycle that follows uses the base tap, wherever it falls in the frame. When `mod_off` returns low, the rest of the frame again follows R3 with the captured code.
- R7: With a base tap of 31, the output stays at tap 31 and `use_hi` stays 0 for the whole frame, whatever the code.
- R8: While `rst` is high, `tap_sel` = 0, `use_hi` = 0 and `frame_start` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_off | input | 1 | Forces the base tap while high |
| tap_idx | input | 5 | Base tap index from the frequency integrator |
| mix_code | input | 5 | Number of upper-tap cycles per frame |
| tap_sel | output | 5 | Registered tap to use in this cycle |
| use_hi | output | 1 | High when this cycle uses the upper tap |
| frame_start | output | 1 | High in the first cycle of each frame |

## Verification
Two functions can act on the same clock edge: capturing a new setting at the frame boundary and the disable override. The bench provokes this on the last cycle of a frame by changing the tap and code and raising `mod_off` together. It then holds the disable for the first four cycles of the new frame. It checks that the new frame starts on the new base tap with no upper-tap cycles. It also checks that, once the disable is released, exactly the positions that R3 assigns to the new code (14 for code 16 from position 4 onward) use the upper tap.

// File: rtl/ftm_pkg.sv
package ftm_pkg;
  localparam int TAP_BITS  = 5;
  localparam int FRAME_LOG = 5;

  typedef struct packed {
    logic [TAP_BITS-1:0]  tap;
    logic [FRAME_LOG-1:0] code;
  } ftm_setting_t;
endpackage

// File: rtl/ftm_frame_ctr.sv
module ftm_frame_ctr #(
  parameter int FRAME_LOG = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [FRAME_LOG-1:0] pos_nxt,
  output logic                 load
);
  logic [FRAME_LOG-1:0] cnt_q;

  // Reset parks the counter on the last slot so the first edge opens a frame.
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '1;
    else     cnt_q <= pos_nxt;
  end

  always_comb begin
    pos_nxt = cnt_q + 1'b1;
    load    = (cnt_q == '1);
  end
endmodule

// File: rtl/ftm_setting_reg.sv
module ftm_setting_reg
  import ftm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [TAP_BITS-1:0]  tap_in,
  input  logic [FRAME_LOG-1:0] code_in,
  output ftm_setting_t         set_nxt,
  output ftm_setting_t         set_q
);
  always_comb begin
    if (load) set_nxt = '{tap: tap_in, code: code_in};
    else      set_nxt = set_q;
  end

  always_ff @(posedge clk) begin
    if (rst) set_q <= '0;
    else     set_q <= set_nxt;
  end

  // R5: the captured setting only moves on a frame boundary
  a_r5_hold_setting: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(set_q));
endmodule

// File: rtl/ftm_mix_out.sv
module ftm_mix_out #(
  parameter int TAP_W  = 5,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_off,
  input  logic [CODE_W-1:0] pos_nxt,
  input  logic [TAP_W-1:0]  tap_nxt,
  input  logic [CODE_W-1:0] code_nxt,
  output logic [TAP_W-1:0]  tap_sel,
  output logic              use_hi,
  output logic              frame_start
);
  localparam logic [TAP_W-1:0] TAP_MAX = '1;

  logic [CODE_W-1:0] pos_rev;
  logic              step_ok;

  for (genvar i = 0; i < CODE_W; i++) begin : g_rev
    assign pos_rev[i] = pos_nxt[CODE_W-1-i];
  end

  always_comb begin
    step_ok = !mod_off && (tap_nxt != TAP_MAX) && (pos_rev < code_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_sel     <= '0;
      use_hi      <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      tap_sel     <= step_ok ? tap_nxt + 1'b1 : tap_nxt;
      use_hi      <= step_ok;
      frame_start <= (pos_nxt == '0);
    end
  end

  // R1: the frame marker is a one-cycle pulse
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
  // R6: disable at an edge gives the base tap in the following cycle
  a_r6_off_base: assert property (@(posedge clk) disable iff (rst)
    mod_off |=> !use_hi);
  // R7: stepping never wraps past the top tap
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    use_hi |-> (tap_sel != '0));
endmodule

// File: rtl/frac_tap_mod.sv
module frac_tap_mod
  import ftm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mod_off,
  input  logic [TAP_BITS-1:0]  tap_idx,
  input  logic [FRAME_LOG-1:0] mix_code,
  output logic [TAP_BITS-1:0]  tap_sel,
  output logic                 use_hi,
  output logic                 frame_start
);
  localparam int HALF = 1 << (FRAME_LOG - 1);

  logic [FRAME_LOG-1:0] pos_nxt;
  logic                 load;
  ftm_setting_t         set_nxt;
  ftm_setting_t         set_q;

  ftm_frame_ctr #(.FRAME_LOG(FRAME_LOG)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .pos_nxt (pos_nxt),
    .load    (load)
  );

  ftm_setting_reg u_set (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .tap_in  (tap_idx),
    .code_in (mix_code),
    .set_nxt (set_nxt),
    .set_q   (set_q)
  );

  ftm_mix_out #(.TAP_W(TAP_BITS), .CODE_W(FRAME_LOG)) u_mix (
    .clk         (clk),
    .rst         (rst),
    .mod_off     (mod_off),
    .pos_nxt     (pos_nxt),
    .tap_nxt     (set_nxt.tap),
    .code_nxt    (set_nxt.code),
    .tap_sel     (tap_sel),
    .use_hi      (use_hi),
    .frame_start (frame_start)
  );

  // R3: low codes never give back-to-back upper-tap cycles
  a_r3_no_adjacent: assert property (@(posedge clk) disable iff (rst)
    (use_hi && (int'(set_q.code) <= HALF)) |=> !use_hi);
  // R4: a zero code keeps the base tap
  a_r4_zero_code: assert property (@(posedge clk) disable iff (rst)
    (set_q.code == '0) |-> !use_hi);
  // R2: the output is the captured tap plus the step flag
  a_r2_tap_sum: assert property (@(posedge clk) disable iff (rst)
    tap_sel == set_q.tap + {{(TAP_BITS-1){1'b0}}, use_hi});
endmodule

// File: tb/frac_tap_mod_tb.sv
module frac_tap_mod_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mod_off = 1'b0;
  logic [4:0] tap_idx = '0;
  logic [4:0] mix_code = '0;
  logic [4:0] tap_sel;
  logic       use_hi;
  logic       frame_start;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  frac_tap_mod u_dut (
    .clk(clk), .rst(rst), .mod_off(mod_off), .tap_idx(tap_idx),
    .mix_code(mix_code), .tap_sel(tap_sel), .use_hi(use_hi),
    .frame_start(frame_start)
  );

  typedef struct packed {
    logic [4:0] tap;
    logic [4:0] code;
    logic       off;
    logic [5:0] cnt;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{5'd5,  5'd0,  1'b0, 6'd0},
    '{5'd5,  5'd1,  1'b0, 6'd1},
    '{5'd12, 5'd16, 1'b0, 6'd16},
    '{5'd3,  5'd31, 1'b0, 6'd31},
    '{5'd20, 5'd7,  1'b0, 6'd7},
    '{5'd9,  5'd25, 1'b1, 6'd0},
    '{5'd31, 5'd20, 1'b0, 6'd0},
    '{5'd30, 5'd31, 1'b0, 6'd31},
    '{5'd0,  5'd13, 1'b0, 6'd13}
  };

  function automatic int rev5(input int p);
    int r = 0;
    for (int i = 0; i < 5; i++) if (p[i]) r |= 1 << (4 - i);
    return r;
  endfunction

  function automatic bit want_hi(input int p, input int tap, input int code);
    return (tap != 31) && (rev5(p) < code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic to_frame_start();
    @(negedge clk);
    while (!frame_start) @(negedge clk);
  endtask

  // Scans one frame from position 0 with constant settings.
  task automatic scan(input int tap, input int code, input bit off, input string req,
                      output int cnt, output int bad, output int adj);
    bit prev = 1'b0;
    cnt = 0; bad = 0; adj = 0;
    for (int p = 0; p < 32; p++) begin
      bit e = !off && want_hi(p, tap, code);
      if (use_hi) cnt++;
      if (use_hi != e || int'(tap_sel) != tap + int'(e)) bad++;
      if (p == 0 && !frame_start) bad++;
      if (p != 0 && frame_start) bad++;
      if (prev && use_hi) adj++;
      prev = use_hi;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin : main
    int cnt, bad, adj;
    // R8: reset state
    repeat (3) @(negedge clk);
    check(tap_sel == 0, "R8 tap_sel in reset", tap_sel, 0);
    check(use_hi == 0, "R8 use_hi in reset", use_hi, 0);
    check(frame_start == 0, "R8 frame_start in reset", frame_start, 0);

    tap_idx = VECS[0].tap; mix_code = VECS[0].code; mod_off = VECS[0].off;
    rst = 1'b0;
    @(negedge clk);
    check(frame_start == 1, "R1 first frame after reset", frame_start, 1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;

    // Table walk: R2, R3, R4, R7, R1
    for (int v = 0; v < NV; v++) begin
      tap_idx = VECS[v].tap; mix_code = VECS[v].code; mod_off = VECS[v].off;
      to_frame_start();
      scan(VECS[v].tap, VECS[v].code, VECS[v].off, "R3", cnt, bad, adj);
      check(cnt == int'(VECS[v].cnt), "R2 upper-tap count", cnt, VECS[v].cnt);
      check(bad == 0, "R3 per-position placement", bad, 0);
      if (VECS[v].code <= 16) check(adj == 0, "R3 no adjacent upper cycles", adj, 0);
      if (VECS[v].tap == 31) check(cnt == 0, "R7 top tap held", cnt, 0);
      if (VECS[v].code == 0) check(cnt == 0, "R4 zero code", cnt, 0);
      check(frame_start == 1, "R1 frame length 32", frame_start, 1);
    end
    mod_off = 1'b0;

    // R5: mid-frame change ignored until the next frame
    tap_idx = 5'd4; mix_code = 5'd8;
    to_frame_start();
    cnt = 0; bad = 0;
    for (int p = 0; p < 32; p++) begin
      if (p == 10) begin tap_idx = 5'd17; mix_code = 5'd30; end
      if (use_hi) cnt++;
      if (int'(tap_sel) != 4 + int'(use_hi)) bad++;
      @(negedge clk);
    end
    check(cnt == 8, "R5 old code kept for frame", cnt, 8);
    check(bad == 0, "R5 old tap kept for frame", bad, 0);
    scan(17, 30, 1'b0, "R5", cnt, bad, adj);
    check(cnt == 30 && bad == 0, "R5 new setting next frame", cnt, 30);

    // R6: disable in mid-frame
    tap_idx = 5'd10; mix_code = 5'd31;
    to_frame_start();
    for (int p = 0; p < 5; p++) @(negedge clk);
    mod_off = 1'b1;
    @(negedge clk);
    check(use_hi == 0 && tap_sel == 10, "R6 off takes effect next cycle", tap_sel, 10);
    for (int p = 6; p < 20; p++) @(negedge clk);
    check(use_hi == 0, "R6 off held", use_hi, 0);
    mod_off = 1'b0;
    @(negedge clk);
    check(use_hi == 1 && tap_sel == 11, "R6 resume at position 21", tap_sel, 11);

    // Coincidence: new setting and disable at the same boundary edge
    tap_idx = 5'd2; mix_code = 5'd0;
    to_frame_start();
    for (int p = 0; p < 31; p++) @(negedge clk);
    tap_idx = 5'd7; mix_code = 5'd16; mod_off = 1'b1;
    @(negedge clk);
    check(frame_start == 1 && tap_sel == 7 && use_hi == 0,
          "R6 boundary with disable", tap_sel, 7);
    cnt = 0;
    for (int p = 0; p < 32; p++) begin
      if (p == 3) mod_off = 1'b0;
      if (use_hi) cnt++;
      @(negedge clk);
    end
    // even positions 4..30 below code 16 after bit reversal: 14
    check(cnt == 14, "R6 R5 combined count", cnt, 14);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule